// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a small serial EEPROM. It runs on the system clock. It samples the two-wire bus lines SCL and SDA after resynchronising them, and it pulls SDA low through an open-drain enable. It recognises start and stop conditions and takes in a header byte. That header holds a fixed four-bit type code, three bits matched against strap inputs, and a direction bit. On a match the block acknowledges and serves byte writes, four-byte page writes, current-address reads, random reads and sequential reads.

The engine owns the word address counter. Write data goes out one byte at a time as an address/data strobe to a separate write-cycle controller. A commit pulse follows on the stop that closes a write transfer. The controller answers with a busy level. While that level is high, the engine does not answer its own header, which gives the usual acknowledge-polling behaviour. Read data comes from a 256x8 array port: the engine presents the address and uses the data that comes back.

The counter wraps in two ways. During writes only the low two bits advance, so the counter stays inside an aligned four-byte page. During reads all eight bits advance and roll over from 255 to 0.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling SDA edge while SCL is high (start) aborts any transfer and restarts header reception. A rising SDA edge while SCL is high (stop) returns the engine to idle with SDA released. In idle, SCL pulses produce no acknowledge.
- R2: The header is taken MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal strap[2:0]. Bit 0 selects the direction: 1 is read, 0 is write. The ninth-clock acknowledge is given only when both fields match.
- R3: After each byte the engine accepts, it holds sda_oe high through the ninth SCL clock and releases it after that clock's falling edge. sda_oe changes only in the cycle after a detected SCL falling edge, start or stop.
- R4: In a write, the first byte after the header loads the word counter. Each later byte is acknowledged and produces one wr_req strobe carrying the counter value and the byte. The counter then advances in its low two bits only (addresses a[7:2]00..a[7:2]11 repeat). A stop after at least one data byte pulses wr_commit.
- R5: In a read, the engine sends the byte at the counter, MSB first, while the bus line is released for 1 bits and pulled low for 0 bits. The counter then advances over all eight bits (255 is followed by 0). Each master acknowledge (SDA low on the ninth clock) starts the next byte.
- R6: When the master leaves SDA high on the ninth clock of a read byte, the engine stops transmitting and keeps SDA released until the next start or stop.
- R7: The counter holds one past the last accessed location. A current-address read returns that byte. A write header plus a word address, followed by a repeated start and a read header, returns the byte at the loaded address.
- R8: While wr_busy is high, a matching header is not acknowledged and SDA stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| strap | input | 3 | Device select straps compared with header bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_busy | input | 1 | Write-cycle controller busy |
| wr_req | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | 8 | Word address for wr_req |
| wr_data | output | 8 | Data byte for wr_req |
| wr_commit | output | 1 | One-cycle pulse on a stop that ends a write with data |
| rd_addr | output | 8 | Array read address (word counter) |
| rd_data | input | 8 | Array read data for rd_addr |

## Verification
Each bus line passes through two synchroniser stages and one edge register, so an SCL or SDA change is seen as an event two clocks after it is sampled. sda_oe follows one clock after that event. wr_commit follows a stop by the same three clocks, and wr_req follows the eighth falling edge of a data byte by the same delay. The bench holds every bus phase for eight clocks. It samples the acknowledge and the read bits in the middle of the SCL high phase, well after sda_oe has settled. It checks sda_oe release only after a full phase of SCL low. Expected read data comes from a bench memory image that is updated with the page-wrap and full-wrap arithmetic of R4 and R5.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;

  // next address inside an aligned page of 2**pbits bytes
  function automatic logic [15:0] page_next(input logic [15:0] a, input int unsigned pbits);
    logic [15:0] m;
    m = (16'd1 << pbits) - 16'd1;
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // next address over the whole aw-bit space
  function automatic logic [15:0] full_next(input logic [15:0] a, input int unsigned aw);
    logic [15:0] m;
    m = (16'd1 << aw) - 16'd1;
    return (a + 16'd1) & m;
  endfunction

  function automatic logic hdr_match(input logic [7:0] hdr, input logic [2:0] straps,
                                     input logic [3:0] code);
    return (hdr[7:4] == code) && (hdr[3:1] == straps);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int LINES = 2;   // index 1 = SCL, index 0 = SDA

  logic [LINES-1:0] raw, cur, prv;
  assign raw = {scl_in, sda_in};

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign cur[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= '1;
    else        prv <= cur;
  end

  assign sda_s    = cur[0];
  assign ev_rise  = cur[1] & ~prv[1];
  assign ev_fall  = ~cur[1] & prv[1];
  assign ev_start = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign ev_stop  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/twi_word_ctr.sv
module twi_word_ctr
  import twi_eeprom_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] ctr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctr <= '0;
    else if (ld)       ctr <= ld_val;
    else if (inc_page) ctr <= AW'(page_next(16'(ctr), PAGE_BITS));
    else if (inc_full) ctr <= AW'(full_next(16'(ctr), AW));
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         PAGE_BITS   = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [2:0]    strap,
  output logic          sda_oe,
  input  logic          wr_busy,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_commit,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int CNT_W = $clog2(DW + 1);

  logic sda_s, ev_rise, ev_fall, ev_start, ev_stop;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  eng_state_t       state, nxt_state;
  logic [DW-1:0]    sr, tx;
  logic [CNT_W-1:0] cnt;
  logic             mack_ok, written;
  logic [AW-1:0]    ctr_q;

  // named internal events
  logic byte_done, hdr_done, hdr_ack, ld_tx, ctr_ld, inc_page;
  assign byte_done = ev_fall && (cnt == CNT_W'(DW));
  assign hdr_done  = byte_done && (state == ST_DEV);
  assign hdr_ack   = hdr_done && hdr_match(sr[7:0], strap, TYPE_CODE) && !wr_busy;
  assign ld_tx     = ev_fall && !ev_stop && !ev_start &&
                     (((state == ST_ACK) && (nxt_state == ST_TX)) ||
                      ((state == ST_MACK) && mack_ok));
  assign ctr_ld    = byte_done && (state == ST_WADDR) && !ev_stop && !ev_start;
  assign inc_page  = byte_done && (state == ST_WDATA) && !ev_stop && !ev_start;

  twi_word_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .ld_val(sr[AW-1:0]),
    .inc_page(inc_page), .inc_full(ld_tx), .ctr(ctr_q)
  );

  assign rd_addr = ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt_state <= ST_IDLE;
      sr        <= '0;
      tx        <= '0;
      cnt       <= '0;
      mack_ok   <= 1'b0;
      written   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_req    <= 1'b0;
      wr_commit <= 1'b0;
      if (ev_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        cnt    <= '0;
        if (written) begin
          wr_commit <= 1'b1;
          written   <= 1'b0;
        end
      end else if (ev_start) begin
        state  <= ST_DEV;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (ev_rise) begin
              sr  <= {sr[DW-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (hdr_ack) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  nxt_state <= sr[0] ? ST_TX : ST_WADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                if (state == ST_WDATA) begin
                  wr_req  <= 1'b1;
                  wr_addr <= ctr_q;
                  wr_data <= sr;
                  written <= 1'b1;
                end
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                nxt_state <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (ev_fall) begin
              state <= nxt_state;
              cnt   <= '0;
              if (nxt_state == ST_TX) begin
                sda_oe <= ~rd_data[DW-1];
                tx     <= {rd_data[DW-2:0], 1'b0};
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (ev_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (ev_fall) begin
              if (cnt == CNT_W'(DW)) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                cnt    <= '0;
              end else begin
                sda_oe <= ~tx[DW-1];
                tx     <= {tx[DW-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (ev_rise) begin
              mack_ok <= ~sda_s;
            end else if (ev_fall) begin
              if (mack_ok) begin
                state  <= ST_TX;
                sda_oe <= ~rd_data[DW-1];
                tx     <= {rd_data[DW-2:0], 1'b0};
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
  parameter int         AW        = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          ev_fall,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          hdr_done,
  input logic          hdr_ack,
  input logic [7:0]    hdr_byte,
  input logic [2:0]    strap,
  input logic          wr_busy,
  input logic          wr_req,
  input logic          wr_commit,
  input logic          ld_tx,
  input logic [AW-1:0] ctr
);
  // R3
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(ev_fall || ev_start || ev_stop));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  // R2
  hdr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ack |-> (hdr_byte[7:4] == TYPE_CODE) && (hdr_byte[3:1] == strap));

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && wr_busy) |=> !sda_oe);

  // R4
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (sda_oe && !wr_busy));

  // R4
  commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !sda_oe);

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_tx |=> (ctr == AW'($past(ctr) + 1'b1)));
endmodule

bind twi_eeprom_slave twi_eeprom_chk #(.AW(AW), .TYPE_CODE(TYPE_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ev_fall(ev_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .hdr_done(hdr_done),
  .hdr_ack(hdr_ack), .hdr_byte(sr[7:0]), .strap(strap), .wr_busy(wr_busy),
  .wr_req(wr_req), .wr_commit(wr_commit), .ld_tx(ld_tx), .ctr(ctr_q)
);

// File: tb/twi_eeprom_slave_bench.sv
module twi_eeprom_slave_bench;
  localparam int          Q     = 8;
  localparam logic [2:0]  STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, wr_req, wr_commit, wr_busy;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ctr;
  int         busy_cnt;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  assign rd_data = mem[rd_addr];
  assign wr_busy = (busy_cnt != 0);

  twi_eeprom_slave u_twi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .strap(STRAP),
    .sda_oe(sda_oe), .wr_busy(wr_busy), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // write-cycle controller model
  always @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (wr_commit) busy_cnt <= 400;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (wr_req) mem[wr_addr] <= wr_data;
  end

  function automatic logic [7:0] pg_nx(input logic [7:0] a);
    return {a[7:2], 2'(a[1:0] + 2'd1)};
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_bus; scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  localparam logic [7:0] HW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] HR = {4'b1010, STRAP, 1'b1};

  task automatic wait_idle();
    while (wr_busy) @(negedge clk);
    wq();
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic       a;
    logic       s;
    logic [7:0] d;
    logic [7:0] ad;
    int         lows;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 5 + 3);
      exp_mem[i] = 8'(i * 5 + 3);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state: bus released, no strobes
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R1 reset wr_req", int'(wr_req), 0);
    chk("R1 reset wr_commit", int'(wr_commit), 0);

    // R2 sweep all write headers
    for (int v = 0; v < 128; v++) begin
      bus_start();
      send_byte({7'(v), 1'b0}, a);
      chk("R2 header ack", int'(a), int'(v[6:3] == 4'b1010 && v[2:0] == int'(STRAP)));
      bus_stop();
    end

    // R4 byte write
    bus_start();
    send_byte(HW, a);   chk("R4 write header ack", int'(a), 1);
    send_byte(8'h10, a); chk("R4 word address ack", int'(a), 1);
    chk("R3 release after ack", int'(sda_oe), 0);
    send_byte(8'hA5, a); chk("R4 data ack", int'(a), 1);
    bus_stop();
    exp_mem[8'h10] = 8'hA5;
    exp_ctr = 8'h11;
    // R8 polling while busy
    bus_start();
    send_byte(HW, a);   chk("R8 no ack while busy", int'(a), 0);
    chk("R8 sda released while busy", int'(sda_oe), 0);
    bus_stop();
    wait_idle();
    bus_start();
    send_byte(HW, a);   chk("R8 ack after busy", int'(a), 1);
    bus_stop();

    // R7 random read
    bus_start();
    send_byte(HW, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(HR, a);   chk("R7 read header ack", int'(a), 1);
    recv_byte(1'b0, d); chk("R7 random read data", int'(d), int'(exp_mem[8'h10]));
    bus_stop();
    exp_ctr = 8'h11;
    // R7 current-address read
    bus_start();
    send_byte(HR, a);
    recv_byte(1'b0, d); chk("R7 current read data", int'(d), int'(exp_mem[exp_ctr]));
    bus_stop();
    exp_ctr = exp_ctr + 8'd1;

    // R4 page write with wrap inside the page
    bus_start();
    send_byte(HW, a);
    send_byte(8'h1E, a);
    ad = 8'h1E;
    for (int k = 0; k < 6; k++) begin
      send_byte(8'(8'h40 + k), a);
      chk("R4 page data ack", int'(a), 1);
      exp_mem[ad] = 8'(8'h40 + k);
      ad = pg_nx(ad);
    end
    bus_stop();
    exp_ctr = ad;
    wait_idle();
    bus_start();
    send_byte(HR, a);
    recv_byte(1'b0, d); chk("R4 counter after page wrap", int'(d), int'(exp_mem[exp_ctr]));
    bus_stop();

    // R5 sequential reads, including the 255 -> 0 roll
    for (int base = 0; base < 2; base++) begin
      logic [7:0] st;
      st = (base == 0) ? 8'h1C : 8'hFE;
      bus_start();
      send_byte(HW, a);
      send_byte(st, a);
      bus_start();
      send_byte(HR, a);
      for (int k = 0; k < 4; k++) begin
        recv_byte(k != 3, d);
        chk("R5 sequential data", int'(d), int'(exp_mem[8'(st + k)]));
      end
      bus_stop();
    end

    // R6 no acknowledge ends transmission
    bus_start();
    send_byte(HR, a);
    recv_byte(1'b0, d);
    lows = 0;
    for (int k = 0; k < 9; k++) begin
      clk_bit(1'b1, s);
      if (!s) lows++;
    end
    chk("R6 silent after nack", lows, 0);
    chk("R6 sda_oe low after nack", int'(sda_oe), 0);
    bus_stop();

    // R1 start aborts a partial header
    bus_start();
    for (int k = 0; k < 4; k++) clk_bit(1'b0, s);
    bus_start();
    send_byte(HW, a);   chk("R1 restart header ack", int'(a), 1);
    send_byte(8'h33, a);
    bus_start();
    send_byte(HR, a);
    recv_byte(1'b0, d); chk("R1 read after restart", int'(d), int'(exp_mem[8'h33]));
    bus_stop();

    // R1 stop returns to idle: bits after stop not acknowledged
    bus_start();
    send_byte(HW, a);
    bus_stop();
    scl_m = 1'b0; wq();
    send_byte(HW, a);   chk("R1 idle after stop", int'(a), 0);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    bus_stop();
    chk("R4 no stray commit", int'(wr_busy), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule